// File: doc/BRIEF.md
# LPC Command Bridge with Register Interface

This block lets a host run single 32-bit transactions on an LPC-side request port by writing and polling a small set of 64-bit registers. The host puts the write payload in the data register. It then writes the control register with a signature, the address-length code, the direction bit and the 32-bit LPC address. A valid control write latches the command and raises a request on the LPC port. The bridge holds that request until the far side answers with an acknowledge or an error, or until a cycle-count watchdog expires. The outcome goes into one status word that the host polls: busy, done, the read data, a 3-bit fault code and a field-check flag.

Bit positions are given in MSB-0 numbering, where bit 0 is the most significant bit of the 64-bit word. The brackets after each position give the plain vector index. Fields that fail the check, and control writes that arrive while a transaction is in flight, do not reach the LPC port. Each is reported in the status word. A write of any value to the reset register returns the bridge to its idle state.

Top module: `lpc_cmd_bridge`

## Requirements
- R1: After reset, `stat_word` is all zero and `lpc_req` is low.
- R2: `hw_sel` selects the register written: 2'b00 control, 2'b01 data, 2'b10 reset; 2'b11 writes nothing. A control write starts a transaction when all of these hold and no transaction is busy: control bits 0:7 [63:56] equal 8'hD4, bits 23:25 [40:38] equal 3'b100, and every other bit outside bit 15 [48] and bits 32:63 [31:0] is zero. The cycle after the write, busy (status bit 44 [19]) is set, done is clear, `lpc_req` is high, `lpc_addr` equals control [31:0], and `lpc_we` is the inverse of control bit 15 [48] (set = read).
- R3: A write takes its payload from data-register bits 0:31 [63:32], latched when the command starts. Later writes to the data register leave `lpc_wdata` unchanged.
- R4: When `lpc_ack` arrives while busy, busy clears and done (status bit 52 [11]) sets on the same edge. For a read, `lpc_rdata` appears in status bits 6:37 [57:26]. Done holds until the next control write or a reset. An acknowledge or error while idle has no effect.
- R5: When `lpc_err` arrives while busy, the transaction completes with fault code 3'b011 in status bits 41:43 [22:20]. Read data is left unchanged.
- R6: A transaction with no answer completes after `wdog_limit`+1 busy cycles, with fault code 3'b100. An acknowledge in that final cycle takes priority and completes without a fault.
- R7: A control write while busy is ignored: `lpc_addr` and `lpc_we` are unchanged. It records fault code 3'b010.
- R8: A control write with a wrong signature or length code does not start. It sets done and fault code 3'b001.
- R9: A control write with a nonzero reserved bit does not start. It sets done and the field-check flag, status bit 56 [7]. A failed transaction always shows a nonzero value under the mask 64'h0000000000700080.
- R10: The fault code keeps its first nonzero value until a new control write is accepted or rejected, or a reset occurs.
- R11: A write of any value to the reset register clears the status word and drops `lpc_req` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 2 | Register select for the write |
| hw_data | input | 64 | Host write data |
| wdog_limit | input | WDOG_W | Watchdog limit in cycles |
| stat_word | output | 64 | Status word for polling |
| lpc_req | output | 1 | LPC request held while busy |
| lpc_we | output | 1 | LPC direction, 1 = write |
| lpc_addr | output | 32 | LPC address |
| lpc_wdata | output | 32 | LPC write payload |
| lpc_ack | input | 1 | LPC acknowledge |
| lpc_err | input | 1 | LPC error response |
| lpc_rdata | input | 32 | LPC read data |

## Verification
The bench builds the bridge with an 8-bit watchdog width. At that width the largest limit, 255, expires after 256 busy cycles, so the saturated counter is reachable in a short run. The bench also drives limits of 0, 2, 3 and 20 at run time. These cover an immediate timeout, an acknowledge that lands in the expiry cycle, and ordinary completions well before expiry.

// File: rtl/lpcb_pkg.sv
package lpcb_pkg;

  localparam int WORD_W = 64;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_CTL = 2'b00;
  localparam logic [SEL_W-1:0] SEL_DAT = 2'b01;
  localparam logic [SEL_W-1:0] SEL_RST = 2'b10;

  localparam logic [7:0] CTL_SIG  = 8'hD4;
  localparam logic [2:0] CTL_LEN4 = 3'b100;

  // MSB-0 positions converted to vector indices
  localparam int CTL_SIG_HI = WORD_W - 1 - 0;
  localparam int CTL_SIG_LO = WORD_W - 1 - 7;
  localparam int CTL_RD     = WORD_W - 1 - 15;
  localparam int CTL_LEN_HI = WORD_W - 1 - 23;
  localparam int CTL_LEN_LO = WORD_W - 1 - 25;
  localparam int CTL_ADR_HI = WORD_W - 1 - 32;
  localparam int CTL_ADR_LO = 0;

  localparam int DAT_PAY_HI = WORD_W - 1;
  localparam int DAT_PAY_LO = WORD_W - DATA_W;

  localparam int ST_RD_HI   = WORD_W - 1 - 6;
  localparam int ST_RD_LO   = WORD_W - 1 - 37;
  localparam int ST_ERR_HI  = WORD_W - 1 - 41;
  localparam int ST_ERR_LO  = WORD_W - 1 - 43;
  localparam int ST_BUSY    = WORD_W - 1 - 44;
  localparam int ST_DONE    = WORD_W - 1 - 52;
  localparam int ST_PAR     = WORD_W - 1 - 56;

  function automatic logic [WORD_W-1:0] ctl_used_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[CTL_SIG_HI:CTL_SIG_LO] = '1;
    m[CTL_RD]                = 1'b1;
    m[CTL_LEN_HI:CTL_LEN_LO] = '1;
    m[CTL_ADR_HI:CTL_ADR_LO] = '1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] CTL_USED = ctl_used_mask();

  typedef enum logic [2:0] {
    FLT_NONE   = 3'b000,
    FLT_FORMAT = 3'b001,
    FLT_PROTO  = 3'b010,
    FLT_BUS    = 3'b011,
    FLT_TMO    = 3'b100
  } fault_e;

endpackage

// File: rtl/lpcb_rst_sync.sv
module lpcb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/lpcb_ctl_decode.sv
module lpcb_ctl_decode
  import lpcb_pkg::*;
(
  input  logic [WORD_W-1:0] ctl,
  output logic              fmt_bad,
  output logic              resv_bad,
  output logic              rd,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    fmt_bad  = (ctl[CTL_SIG_HI:CTL_SIG_LO] != CTL_SIG) ||
               (ctl[CTL_LEN_HI:CTL_LEN_LO] != CTL_LEN4);
    resv_bad = |(ctl & ~CTL_USED);
    rd       = ctl[CTL_RD];
    addr     = ctl[CTL_ADR_HI:CTL_ADR_LO];
  end

endmodule

// File: rtl/lpcb_wdog.sv
module lpcb_wdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    expired = (cnt_q == limit);
    cnt_en  = clr | (run & ~expired);
    cnt_d   = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6: the count only moves while a request is pending or on a clear
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/lpc_cmd_bridge.sv
module lpc_cmd_bridge
  import lpcb_pkg::*;
#(
  parameter int WDOG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [SEL_W-1:0]  hw_sel,
  input  logic [WORD_W-1:0] hw_data,
  input  logic [WDOG_W-1:0] wdog_limit,
  output logic [WORD_W-1:0] stat_word,
  output logic              lpc_req,
  output logic              lpc_we,
  output logic [ADDR_W-1:0] lpc_addr,
  output logic [DATA_W-1:0] lpc_wdata,
  input  logic              lpc_ack,
  input  logic              lpc_err,
  input  logic [DATA_W-1:0] lpc_rdata
);

  logic rst_ni;

  lpcb_rst_sync #(.STAGES(2)) u_rsync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_ni)
  );

  // host strobes
  logic wr_ctl, wr_dat, wr_rst;
  always_comb begin
    wr_ctl = hw_en && (hw_sel == SEL_CTL);
    wr_dat = hw_en && (hw_sel == SEL_DAT);
    wr_rst = hw_en && (hw_sel == SEL_RST);
  end

  logic              dec_fmt_bad, dec_resv_bad, dec_rd;
  logic [ADDR_W-1:0] dec_addr;

  lpcb_ctl_decode u_dec (
    .ctl      (hw_data),
    .fmt_bad  (dec_fmt_bad),
    .resv_bad (dec_resv_bad),
    .rd       (dec_rd),
    .addr     (dec_addr)
  );

  // state
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              par_q, par_d;
  fault_e            code_q, code_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] dreg_q, dreg_d;

  logic start, reject, proto;
  logic fin_err, fin_ok, fin_tmo;
  logic wd_exp;
  fault_e cerr;
  logic st_en, cmd_en, dat_en;

  lpcb_wdog #(.W(WDOG_W)) u_wdog (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .clr     (start | wr_rst),
    .run     (busy_q & ~lpc_ack & ~lpc_err & ~wr_rst),
    .limit   (wdog_limit),
    .expired (wd_exp)
  );

  always_comb begin
    start   = wr_ctl & ~busy_q & ~dec_fmt_bad & ~dec_resv_bad;
    reject  = wr_ctl & ~busy_q & (dec_fmt_bad | dec_resv_bad);
    proto   = wr_ctl & busy_q;
    fin_err = busy_q & lpc_err;
    fin_ok  = busy_q & ~lpc_err & lpc_ack;
    fin_tmo = busy_q & ~lpc_err & ~lpc_ack & wd_exp;
    cerr    = fin_err ? FLT_BUS : (fin_tmo ? FLT_TMO : FLT_NONE);

    st_en   = wr_rst | wr_ctl | busy_q;
    cmd_en  = wr_rst | start;
    dat_en  = wr_rst | wr_dat;
  end

  // next state
  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    par_d   = par_q;
    code_d  = code_q;
    rdata_d = rdata_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    dreg_d  = dreg_q;

    if (fin_err || fin_ok || fin_tmo) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
    if (fin_ok && !we_q) rdata_d = lpc_rdata;

    // first nonzero fault is kept
    if (code_q == FLT_NONE)
      code_d = (cerr != FLT_NONE) ? cerr : (proto ? FLT_PROTO : FLT_NONE);

    if (wr_dat) dreg_d = hw_data[DAT_PAY_HI:DAT_PAY_LO];

    if (start) begin
      busy_d  = 1'b1;
      done_d  = 1'b0;
      code_d  = FLT_NONE;
      par_d   = 1'b0;
      we_d    = ~dec_rd;
      addr_d  = dec_addr;
      wdata_d = dreg_q;
    end

    if (reject) begin
      done_d = 1'b1;
      code_d = dec_fmt_bad ? FLT_FORMAT : FLT_NONE;
      par_d  = dec_resv_bad;
    end

    if (wr_rst) begin
      busy_d  = 1'b0;
      done_d  = 1'b0;
      par_d   = 1'b0;
      code_d  = FLT_NONE;
      rdata_d = '0;
      we_d    = 1'b0;
      addr_d  = '0;
      wdata_d = '0;
      dreg_d  = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      par_q   <= 1'b0;
      code_q  <= FLT_NONE;
      rdata_q <= '0;
    end else if (st_en) begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      par_q   <= par_d;
      code_q  <= code_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cmd_en) begin
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     dreg_q <= '0;
    else if (dat_en) dreg_q <= dreg_d;
  end

  // outputs
  always_comb begin
    stat_word                     = '0;
    stat_word[ST_RD_HI:ST_RD_LO]  = rdata_q;
    stat_word[ST_ERR_HI:ST_ERR_LO] = code_q;
    stat_word[ST_BUSY]            = busy_q;
    stat_word[ST_DONE]            = done_q;
    stat_word[ST_PAR]             = par_q;
  end

  assign lpc_req   = busy_q;
  assign lpc_we    = we_q;
  assign lpc_addr  = addr_q;
  assign lpc_wdata = wdata_q;

  // R2: an accepted control write raises the request next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> (lpc_req && stat_word[ST_BUSY] && !stat_word[ST_DONE]));

  // R4: busy and done are never both set
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !(stat_word[ST_BUSY] && stat_word[ST_DONE]));

  // R4: acknowledge completes in one edge
  p_ack_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && lpc_ack && !lpc_err && !wr_rst) |=> (!lpc_req && stat_word[ST_DONE]));

  // R5: error response reports the bus fault code
  p_bus_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && lpc_err && code_q == FLT_NONE && !wr_rst)
      |=> (stat_word[ST_ERR_HI:ST_ERR_LO] == 3'b011));

  // R6: watchdog expiry ends the request
  p_tmo_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && wd_exp && !lpc_ack && !lpc_err && !wr_rst)
      |=> (!lpc_req && stat_word[ST_DONE]));

  // R7: control write while busy leaves the command untouched
  p_ign_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    proto |=> ($stable(lpc_addr) && $stable(lpc_we) && lpc_req == !$past(lpc_ack || lpc_err || wd_exp)));

  // R8: a rejected control write never raises the request
  p_rej_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    reject |=> (!lpc_req && stat_word[ST_DONE]));

  // R11: reset register write clears everything
  p_clr_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_rst |=> (stat_word == '0 && !lpc_req));

endmodule

// File: tb/sim_lpc_cmd_bridge.sv
`timescale 1ns/1ps
module sim_lpc_cmd_bridge;

  localparam int WW = 8;
  localparam logic [63:0] CTL_BASE = 64'hD400_0100_0000_0000;
  localparam logic [63:0] RD_BIT   = 64'h0001_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_en;
  logic [1:0]  hw_sel;
  logic [63:0] hw_data;
  logic [WW-1:0] wdog_limit;
  logic [63:0] stat_word;
  logic        lpc_req, lpc_we;
  logic [31:0] lpc_addr, lpc_wdata, lpc_rdata;
  logic        lpc_ack, lpc_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lpc_cmd_bridge #(.WDOG_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .wdog_limit(wdog_limit), .stat_word(stat_word), .lpc_req(lpc_req),
    .lpc_we(lpc_we), .lpc_addr(lpc_addr), .lpc_wdata(lpc_wdata),
    .lpc_ack(lpc_ack), .lpc_err(lpc_err), .lpc_rdata(lpc_rdata)
  );

  // behavioural reference model
  bit        m_busy, m_done, m_par, m_we;
  bit [2:0]  m_code;
  bit [31:0] m_rdata, m_addr, m_wdata, m_dreg;
  int        m_cnt;

  function automatic bit [63:0] m_stat();
    bit [63:0] s;
    s = '0;
    s[57:26] = m_rdata;
    s[22:20] = m_code;
    s[19]    = m_busy;
    s[11]    = m_done;
    s[7]     = m_par;
    return s;
  endfunction

  task automatic m_clear();
    m_busy = 0; m_done = 0; m_par = 0; m_we = 0; m_code = 0;
    m_rdata = 0; m_addr = 0; m_wdata = 0; m_dreg = 0; m_cnt = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    bit obusy, proto, sig_ok, len_ok, resv;
    bit [2:0] ce;
    if (!rst_n) begin
      m_clear();
    end else if (hw_en && hw_sel == 2'b10) begin
      m_clear();
    end else begin
      obusy = m_busy;
      ce    = 0;
      proto = hw_en && hw_sel == 2'b00 && obusy;
      if (obusy) begin
        if (lpc_err) begin m_busy = 0; m_done = 1; ce = 3'd3; end
        else if (lpc_ack) begin
          m_busy = 0; m_done = 1;
          if (!m_we) m_rdata = lpc_rdata;
        end
        else if (m_cnt == int'(wdog_limit)) begin m_busy = 0; m_done = 1; ce = 3'd4; end
        else m_cnt++;
      end
      if (m_code == 0) m_code = (ce != 0) ? ce : (proto ? 3'd2 : 3'd0);
      if (hw_en && hw_sel == 2'b00 && !obusy) begin
        sig_ok = hw_data[63:56] == 8'hD4;
        len_ok = hw_data[40:38] == 3'b100;
        resv   = (hw_data[55:49] != 0) || (hw_data[47:41] != 0) || (hw_data[37:32] != 0);
        if (sig_ok && len_ok && !resv) begin
          m_busy = 1; m_done = 0; m_code = 0; m_par = 0; m_cnt = 0;
          m_we = !hw_data[48]; m_addr = hw_data[31:0]; m_wdata = m_dreg;
        end else begin
          m_done = 1;
          m_code = (sig_ok && len_ok) ? 3'd0 : 3'd1;
          m_par  = resv;
        end
      end
      if (hw_en && hw_sel == 2'b01) m_dreg = hw_data[63:32];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(stat_word === m_stat(), "R4 status word vs model", stat_word, m_stat());
    chk(lpc_req === m_busy, "R2 lpc_req vs model", 64'(lpc_req), 64'(m_busy));
    chk(lpc_we === m_we, "R2 lpc_we vs model", 64'(lpc_we), 64'(m_we));
    chk(lpc_addr === m_addr, "R2 lpc_addr vs model", 64'(lpc_addr), 64'(m_addr));
    chk(lpc_wdata === m_wdata, "R3 lpc_wdata vs model", 64'(lpc_wdata), 64'(m_wdata));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic hw(input logic [1:0] sel, input logic [63:0] d);
    hw_en = 1; hw_sel = sel; hw_data = d;
    tick();
    hw_en = 0; hw_sel = 2'b11; hw_data = '0;
  endtask

  task automatic resp(input bit ack, input bit err, input logic [31:0] rd);
    lpc_ack = ack; lpc_err = err; lpc_rdata = rd;
    tick();
    lpc_ack = 0; lpc_err = 0; lpc_rdata = '0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (stat_word[19] && n < 400) begin n++; tick(); end
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    int n;
    rst_n = 0; hw_en = 0; hw_sel = 2'b11; hw_data = '0;
    wdog_limit = 8'd20; lpc_ack = 0; lpc_err = 0; lpc_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset state
    chk(stat_word == 64'h0, "R1 status after reset", stat_word, 64'h0);
    chk(lpc_req == 1'b0, "R1 request after reset", 64'(lpc_req), 64'h0);

    // R2 R3 write transaction
    hw(2'b01, 64'hCAFE_BABE_1111_2222);
    hw(2'b00, CTL_BASE | 64'h0000_1234);
    chk(lpc_req && stat_word[19], "R2 busy and request after start", stat_word, 64'h80000);
    chk(lpc_we == 1'b1, "R2 direction write", 64'(lpc_we), 64'h1);
    chk(lpc_addr == 32'h1234, "R2 address", 64'(lpc_addr), 64'h1234);
    chk(lpc_wdata == 32'hCAFE_BABE, "R3 payload", 64'(lpc_wdata), 64'hCAFEBABE);
    hw(2'b01, 64'h0123_4567_0000_0000);
    chk(lpc_wdata == 32'hCAFE_BABE, "R3 payload held", 64'(lpc_wdata), 64'hCAFEBABE);
    idle(2);
    resp(1, 0, 32'h0);
    chk(!stat_word[19] && stat_word[11], "R4 done after ack", stat_word, 64'h800);
    chk(stat_word[22:20] == 3'b000, "R4 no fault", 64'(stat_word[22:20]), 64'h0);

    // R4 read transaction
    hw(2'b00, CTL_BASE | RD_BIT | 64'h0000_00F0);
    chk(lpc_we == 1'b0, "R2 direction read", 64'(lpc_we), 64'h0);
    idle(3);
    resp(1, 0, 32'h89AB_CDEF);
    chk(stat_word[57:26] == 32'h89AB_CDEF, "R4 read data", 64'(stat_word[57:26]), 64'h89ABCDEF);
    idle(3);
    chk(stat_word[11] == 1'b1, "R4 done holds", 64'(stat_word[11]), 64'h1);
    snap = stat_word;
    resp(1, 0, 32'h5555_5555);
    resp(0, 1, 32'h0);
    chk(stat_word == snap, "R4 response while idle ignored", stat_word, snap);

    // R5 error response on a read
    hw(2'b00, CTL_BASE | RD_BIT | 64'h0000_0044);
    chk(stat_word[11] == 1'b0, "R4 done cleared by new command", 64'(stat_word[11]), 64'h0);
    resp(0, 1, 32'hFFFF_FFFF);
    chk(stat_word[22:20] == 3'b011, "R5 bus fault code", 64'(stat_word[22:20]), 64'h3);
    chk(stat_word[57:26] == 32'h89AB_CDEF, "R5 read data kept", 64'(stat_word[57:26]), 64'h89ABCDEF);

    // R6 timeout, small limit
    wdog_limit = 8'd3;
    hw(2'b00, CTL_BASE | RD_BIT | 64'h0000_0010);
    wait_idle(n);
    chk(n == 4, "R6 busy cycles limit 3", 64'(n), 64'd4);
    chk(stat_word[22:20] == 3'b100 && stat_word[11], "R6 timeout code", 64'(stat_word[22:20]), 64'h4);

    // R6 limit zero
    wdog_limit = 8'd0;
    hw(2'b00, CTL_BASE | 64'h0000_0020);
    wait_idle(n);
    chk(n == 1, "R6 busy cycles limit 0", 64'(n), 64'd1);

    // R6 acknowledge in the expiry cycle wins
    wdog_limit = 8'd2;
    hw(2'b00, CTL_BASE | 64'h0000_0030);
    idle(2);
    resp(1, 0, 32'h0);
    chk(stat_word[22:20] == 3'b000 && stat_word[11], "R6 ack beats expiry", 64'(stat_word[22:20]), 64'h0);

    // R6 saturated width
    wdog_limit = 8'd255;
    hw(2'b00, CTL_BASE | 64'h0000_0040);
    wait_idle(n);
    chk(n == 256, "R6 busy cycles limit 255", 64'(n), 64'd256);

    // R7 R10 control write while busy
    wdog_limit = 8'd20;
    hw(2'b00, CTL_BASE | 64'h0000_0100);
    hw(2'b00, CTL_BASE | RD_BIT | 64'h0000_0200);
    chk(lpc_addr == 32'h100 && lpc_we == 1'b1, "R7 command unchanged", 64'(lpc_addr), 64'h100);
    chk(stat_word[22:20] == 3'b010 && stat_word[19], "R7 protocol code", 64'(stat_word[22:20]), 64'h2);
    resp(0, 1, 32'h0);
    chk(stat_word[22:20] == 3'b010, "R10 first fault kept", 64'(stat_word[22:20]), 64'h2);
    hw(2'b00, CTL_BASE | 64'h0000_0300);
    chk(stat_word[22:20] == 3'b000, "R10 fault cleared by accepted command", 64'(stat_word[22:20]), 64'h0);
    resp(1, 0, 32'h0);

    // R8 bad signature and bad length
    hw(2'b00, 64'hD500_0100_0000_0400);
    chk(!lpc_req && stat_word[11] && stat_word[22:20] == 3'b001, "R8 bad signature", stat_word, 64'h100800);
    hw(2'b00, 64'hD400_0080_0000_0400);
    chk(!lpc_req && stat_word[22:20] == 3'b001, "R8 bad length", stat_word, 64'h100800);

    // R9 reserved bit set
    hw(2'b00, CTL_BASE | 64'h0000_0002_0000_0500);
    chk(!lpc_req && stat_word[7] && stat_word[11], "R9 field-check flag", stat_word, 64'h880);
    chk((stat_word & 64'h0000_0000_0070_0080) != 0, "R9 mask shows failure", stat_word, 64'h80);

    // R11 reset register during a transaction
    hw(2'b01, 64'hAAAA_AAAA_0000_0000);
    hw(2'b00, CTL_BASE | 64'h0000_0600);
    hw(2'b10, 64'h0);
    chk(stat_word == 64'h0 && !lpc_req, "R11 clear by reset register", stat_word, 64'h0);
    snap = stat_word;
    hw(2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(stat_word == snap && !lpc_req, "R2 select 3 writes nothing", stat_word, snap);
    hw(2'b00, CTL_BASE | 64'h0000_0700);
    chk(lpc_wdata == 32'h0, "R11 data register cleared", 64'(lpc_wdata), 64'h0);
    resp(1, 0, 32'h0);
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule